// File: doc/BRIEF.md
# I2C Target with Persistent Register Pointer

This block is the serial front end of a small register file that sits on an I2C bus as a target. It oversamples the bus clock and data lines with the system clock and finds START, repeated START and STOP conditions. It recognises one fixed 7-bit device address and drives SDA in open-drain fashion. A single enable output pulls the line low, and the pad and the pull-up resistor supply the high level.

A write transaction first loads an internal register pointer. It may then carry one data byte, which the block hands to the back end as a single-cycle write strobe. A read transaction returns the register that the pointer selects. The read can follow a repeated START, or it can stand on its own right after START. The pointer keeps its value between transactions and never advances, so the same register can be read again and again without sending a pointer byte. After reset the pointer is zero.

The back end sees the pointer as a read address and supplies the read data combinationally. Writes reach the back end as a strobe carrying the address and the data.

Top module: `i2c_ptr_target`

## Requirements
- R1: After reset, `sda_oe` is 0, `reg_we` is 0 and `reg_raddr` is 0.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high, both judged on the synchronized lines. A START at any point abandons the current transfer and begins a new address byte. After STOP the block is idle with SDA released.
- R3: The first byte after START holds the 7-bit address in bits 7..1 and R/W in bit 0 (1 = read). On a match with `DEV_ADDR` the block pulls SDA low during the ninth clock. On a mismatch it does not acknowledge and ignores every bit until the next START.
- R4: In a write (R/W = 0), the first byte after the address loads the pointer, is acknowledged, and appears on `reg_raddr`.
- R5: A second write byte is acknowledged and produces one write strobe with `reg_waddr` equal to the pointer and `reg_wdata` equal to the byte. The pointer is unchanged. Any further byte in that transaction is not acknowledged.
- R6: In a read (R/W = 1), after its address ACK the block shifts out the register at the pointer, MSB first. It pulls SDA low (`sda_oe` = 1) for each 0 bit.
- R7: When the controller ACKs a read byte and keeps clocking, the same register value is sent again. There is no auto-increment.
- R8: When the controller NACKs a read byte, SDA stays released until the next START or STOP.
- R9: The pointer persists across STOP. A read that follows START directly returns the register at the stored pointer.
- R10: The read value is captured when the matching read address byte completes. A change on `reg_rdata` during the shifting or the resends does not alter the bits on the bus.
- R11: `sda_oe` changes only while SCL is low.
- R12: `reg_we` never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| reg_raddr | output | PTR_W | Register pointer, used as read address |
| reg_rdata | input | 8 | Read data for `reg_raddr` |
| reg_we | output | 1 | Single-cycle write strobe |
| reg_waddr | output | PTR_W | Write address |
| reg_wdata | output | 8 | Write data |

## Verification
The hardest condition to create from the ports is a change of back-end data in the middle of a read, because the register contents never change on their own. The bench masks its register model with an XOR. It switches the mask on right after the read address ACK, keeps it on across a controller ACK and a resent byte, and expects the bus to carry the value from before the change. A second hard case is a bus left silent after a controller NACK. The bench keeps clocking a whole byte with SDA released and checks that the line stays high at every sample.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK,
        ST_PTR,
        ST_WDATA,
        ST_TX,
        ST_MACK,
        ST_IGNORE
    } tgt_state_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_pipe;
        logic [SYNC_STAGES-1:0] sda_pipe;
        logic                   scl_prev;
        logic                   sda_prev;
    } sync_t;

    sync_t q, d;

    always_comb begin
        d          = q;
        d.scl_pipe = {q.scl_pipe[SYNC_STAGES-2:0], scl_i};
        d.sda_pipe = {q.sda_pipe[SYNC_STAGES-2:0], sda_i};
        d.scl_prev = q.scl_pipe[SYNC_STAGES-1];
        d.sda_prev = q.sda_pipe[SYNC_STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '1;
        end else begin
            q <= d;
        end
    end

    assign scl_lvl   = q.scl_pipe[SYNC_STAGES-1];
    assign sda_lvl   = q.sda_pipe[SYNC_STAGES-1];
    assign scl_rise  = scl_lvl & ~q.scl_prev;
    assign scl_fall  = ~scl_lvl & q.scl_prev;
    assign start_det = scl_lvl & q.scl_prev & q.sda_prev & ~sda_lvl;
    assign stop_det  = scl_lvl & q.scl_prev & ~q.sda_prev & sda_lvl;

endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h48,
    parameter int         PTR_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_lvl,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [BYTE_W-1:0] rd_data,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  ptr,
    output logic              we,
    output logic [PTR_W-1:0]  waddr,
    output logic [BYTE_W-1:0] wdata
);

    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
    localparam logic [CNT_W-1:0] ALL_BITS = CNT_W'(BYTE_W);

    typedef struct packed {
        tgt_state_e        st;
        tgt_state_e        ack_next;
        logic              ack_on;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] rlat;
        logic [PTR_W-1:0]  ptr;
        logic              oe;
        logic              we;
        logic [PTR_W-1:0]  waddr;
        logic [BYTE_W-1:0] wdata;
    } eng_t;

    eng_t q, d;
    logic [BYTE_W-1:0] sh_in;

    assign sh_in = {q.sh[BYTE_W-2:0], sda_lvl};

    always_comb begin
        d    = q;
        d.we = 1'b0;
        if (start_det) begin
            d.st     = ST_ADDR;
            d.cnt    = '0;
            d.oe     = 1'b0;
            d.ack_on = 1'b0;
        end else if (stop_det) begin
            d.st     = ST_IDLE;
            d.cnt    = '0;
            d.oe     = 1'b0;
            d.ack_on = 1'b0;
        end else begin
            unique case (q.st)
                ST_ADDR, ST_PTR, ST_WDATA: begin
                    if (scl_rise) begin
                        d.sh  = sh_in;
                        d.cnt = q.cnt + 1'b1;
                        if (q.cnt == LAST_BIT) begin
                            d.cnt    = '0;
                            d.st     = ST_ACK;
                            d.ack_on = 1'b0;
                            if (q.st == ST_ADDR) begin
                                if (sh_in[BYTE_W-1:1] == DEV_ADDR) begin
                                    if (sh_in[0]) begin
                                        d.ack_next = ST_TX;
                                        d.rlat     = rd_data;
                                    end else begin
                                        d.ack_next = ST_PTR;
                                    end
                                end else begin
                                    d.st = ST_IGNORE;
                                end
                            end else if (q.st == ST_PTR) begin
                                d.ptr      = sh_in[PTR_W-1:0];
                                d.ack_next = ST_WDATA;
                            end else begin
                                d.we       = 1'b1;
                                d.waddr    = q.ptr;
                                d.wdata    = sh_in;
                                d.ack_next = ST_IGNORE;
                            end
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (!q.ack_on) begin
                            d.ack_on = 1'b1;
                            d.oe     = 1'b1;
                        end else begin
                            d.ack_on = 1'b0;
                            d.st     = q.ack_next;
                            d.cnt    = '0;
                            if (q.ack_next == ST_TX) begin
                                d.sh = q.rlat;
                                d.oe = ~q.rlat[BYTE_W-1];
                            end else begin
                                d.oe = 1'b0;
                            end
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (q.cnt == ALL_BITS) begin
                            d.oe  = 1'b0;
                            d.cnt = '0;
                            d.st  = ST_MACK;
                        end else begin
                            d.sh = q.sh << 1;
                            d.oe = ~q.sh[BYTE_W-2];
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        if (sda_lvl) begin
                            d.st = ST_IGNORE;
                        end else begin
                            d.cnt = CNT_W'(1);
                        end
                    end else if (scl_fall && q.cnt == CNT_W'(1)) begin
                        d.st  = ST_TX;
                        d.cnt = '0;
                        d.sh  = q.rlat;
                        d.oe  = ~q.rlat[BYTE_W-1];
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.ack_next <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe = q.oe;
    assign ptr    = q.ptr;
    assign we     = q.we;
    assign waddr  = q.waddr;
    assign wdata  = q.wdata;

    // R11: the SDA drive moves only in a cycle that follows a low SCL sample
    a_r11_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.oe) |-> !$past(scl_lvl));

    // R12: the write strobe lasts one cycle
    a_r12_we_single: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |=> !q.we);

    // R4: the pointer changes only on completion of a pointer byte
    a_r4_ptr_from_ptr_byte: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(q.ptr) |-> $past(q.st) == ST_PTR);

    // R5: a strobe appears only in the acknowledge of the data byte
    a_r5_we_in_data_ack: assert property (@(posedge clk) disable iff (!rst_n)
        q.we |-> (q.st == ST_ACK && q.ack_next == ST_IGNORE));

    // R8: no drive while the bus is being ignored
    a_r8_silent_ignore: assert property (@(posedge clk) disable iff (!rst_n)
        q.st == ST_IGNORE |-> !q.oe);

    // R2: START opens a fresh address byte with SDA released
    a_r2_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (q.st == ST_ADDR && !q.oe));

endmodule

// File: rtl/i2c_ptr_target.sv
module i2c_ptr_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR    = 7'h48,
    parameter int         PTR_W       = 8,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [PTR_W-1:0]  reg_raddr,
    input  logic [BYTE_W-1:0] reg_rdata,
    output logic              reg_we,
    output logic [PTR_W-1:0]  reg_waddr,
    output logic [BYTE_W-1:0] reg_wdata
);

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;

    i2c_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    i2c_tgt_engine #(
        .DEV_ADDR(DEV_ADDR),
        .PTR_W   (PTR_W)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .rd_data  (reg_rdata),
        .sda_oe   (sda_oe),
        .ptr      (reg_raddr),
        .we       (reg_we),
        .waddr    (reg_waddr),
        .wdata    (reg_wdata)
    );

endmodule

// File: tb/test_i2c_ptr_target.sv
module test_i2c_ptr_target;

    localparam logic [6:0] DEV = 7'h48;
    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [7:0] reg_raddr, reg_rdata, reg_waddr, reg_wdata;
    logic       reg_we;
    logic [7:0] tear_mask = 8'h00;

    int total = 0;
    int bad = 0;

    // reference model: register contents, pointer, pending writes
    logic [7:0] mem [0:255];
    logic [7:0] model_ptr = 8'h00;
    bit         ptr_busy = 1'b0;
    logic [15:0] wr_q [$];

    always #10 clk = ~clk;

    assign sda_line  = sda_m & ~sda_oe;
    assign reg_rdata = mem[reg_raddr] ^ tear_mask;

    i2c_ptr_target #(.DEV_ADDR(DEV)) i_i2c_ptr_target (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .reg_raddr(reg_raddr),
        .reg_rdata(reg_rdata),
        .reg_we   (reg_we),
        .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // per-clock comparison against the model
    logic prev_scl = 1'b1, prev_oe = 1'b0, prev_we = 1'b0;
    int   r11_bad = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (wr_q.size() == 0) begin
                    check(1'b0, "R5 unexpected strobe", {reg_waddr, reg_wdata}, 0);
                end else begin
                    logic [15:0] e;
                    e = wr_q.pop_front();
                    check({reg_waddr, reg_wdata} == e, "R5 strobe addr/data", {reg_waddr, reg_wdata}, e);
                end
                mem[reg_waddr] = reg_wdata;
            end
            if (reg_we && prev_we) check(1'b0, "R12 strobe longer than one cycle", 2, 1);
            if (!ptr_busy && reg_raddr != model_ptr)
                check(1'b0, "R9 pointer vs model", reg_raddr, model_ptr);
            if (scl && prev_scl && sda_oe != prev_oe) begin
                r11_bad++;
                check(1'b0, "R11 SDA moved with SCL high", sda_oe, prev_oe);
            end
        end
        prev_scl = scl;
        prev_oe  = sda_oe;
        prev_we  = reg_we;
    end

    task automatic qwait();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qwait();
        scl = 1'b1;   qwait();
        sda_m = 1'b0; qwait();
        scl = 1'b0;   qwait();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qwait();
        scl = 1'b1;   qwait();
        sda_m = 1'b1; qwait();
    endtask

    task automatic bus_bit(input logic b, output logic seen);
        sda_m = b;  qwait();
        scl = 1'b1; qwait();
        seen = sda_line; qwait();
        scl = 1'b0; qwait();
    endtask

    task automatic send_byte(input logic [7:0] v, output logic acked);
        logic s;
        for (int i = 7; i >= 0; i--) bus_bit(v[i], s);
        bus_bit(1'b1, s);
        acked = ~s;
    endtask

    task automatic recv_byte(output logic [7:0] v, input logic give_ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bus_bit(1'b1, s);
            v[i] = s;
        end
        bus_bit(~give_ack, s);
    endtask

    task automatic set_ptr(input logic [7:0] p, input string req);
        logic a;
        bus_start();
        send_byte({DEV, 1'b0}, a);
        check(a, {req, " write address ACK (R3)"}, a, 1);
        ptr_busy = 1'b1;
        send_byte(p, a);
        check(a, {req, " pointer byte ACK (R4)"}, a, 1);
        model_ptr = p;
        ptr_busy = 1'b0;
        check(reg_raddr == p, {req, " pointer on reg_raddr (R4)"}, reg_raddr, p);
    endtask

    task automatic read_only(input string req);
        logic a;
        logic [7:0] v;
        bus_start();
        send_byte({DEV, 1'b1}, a);
        check(a, {req, " read address ACK (R3)"}, a, 1);
        recv_byte(v, 1'b0);
        check(v == mem[model_ptr], req, v, mem[model_ptr]);
        bus_stop();
    endtask

    initial begin
        repeat (300000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic a, s;
        logic [7:0] v;
        for (int i = 0; i < 256; i++) mem[i] = 8'(i * 37 + 5);

        repeat (5) @(negedge clk);
        // R1: reset state
        check(sda_oe == 1'b0, "R1 sda_oe after reset", sda_oe, 0);
        check(reg_we == 1'b0, "R1 reg_we after reset", reg_we, 0);
        check(reg_raddr == 8'h00, "R1 pointer after reset", reg_raddr, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R9 / R6: read at the reset pointer without a pointer byte
        read_only("R9 R6 read at pointer 0");

        // R3: address mismatch, no ACK and the following byte is ignored
        bus_start();
        send_byte({DEV ^ 7'h01, 1'b0}, a);
        check(!a, "R3 no ACK on foreign address", a, 0);
        send_byte(8'h00, a);
        check(!a, "R3 byte after foreign address ignored", a, 0);
        bus_stop();
        check(reg_raddr == 8'h00, "R3 pointer untouched after mismatch", reg_raddr, 0);

        // R4: pointer-only write
        set_ptr(8'h35, "R4 pointer-only write");
        bus_stop();
        check(sda_oe == 1'b0, "R2 SDA released after STOP", sda_oe, 0);

        // R7: repeated START read with controller ACKs, same value each time
        set_ptr(8'h12, "R7 set pointer");
        bus_start();
        send_byte({DEV, 1'b1}, a);
        check(a, "R7 read address ACK after repeated START (R2)", a, 1);
        for (int k = 0; k < 3; k++) begin
            recv_byte(v, 1'b1);
            check(v == mem[8'h12], "R7 resend after controller ACK", v, mem[8'h12]);
        end
        recv_byte(v, 1'b0);
        check(v == mem[8'h12], "R7 last byte before NACK", v, mem[8'h12]);
        bus_stop();

        // R9: pointer kept across STOP
        read_only("R9 read-only returns stored pointer");

        // R5: pointer plus one data byte, extra byte refused
        set_ptr(8'h40, "R5 set pointer");
        wr_q.push_back({8'h40, 8'h5C});
        send_byte(8'h5C, a);
        check(a, "R5 data byte ACK", a, 1);
        send_byte(8'h77, a);
        check(!a, "R5 third byte not acknowledged", a, 0);
        bus_stop();
        check(wr_q.size() == 0, "R5 exactly one strobe seen", wr_q.size(), 0);
        check(reg_raddr == 8'h40, "R5 pointer unchanged by data write", reg_raddr, 8'h40);
        read_only("R5 read back written data");

        // R8: after controller NACK the line stays released for a full byte
        bus_start();
        send_byte({DEV, 1'b1}, a);
        recv_byte(v, 1'b0);
        check(v == mem[8'h40], "R8 value before NACK", v, mem[8'h40]);
        for (int i = 0; i < 9; i++) begin
            bus_bit(1'b1, s);
            check(s == 1'b1, "R8 SDA released after NACK", s, 1);
        end
        bus_stop();

        // R10: back-end data changes after the address ACK
        set_ptr(8'h07, "R10 set pointer");
        bus_start();
        send_byte({DEV, 1'b1}, a);
        tear_mask = 8'hFF;
        recv_byte(v, 1'b1);
        check(v == mem[8'h07], "R10 first byte uses captured value", v, mem[8'h07]);
        recv_byte(v, 1'b0);
        check(v == mem[8'h07], "R10 resend uses captured value", v, mem[8'h07]);
        bus_stop();
        tear_mask = 8'h00;

        // R2: a transfer cut by START, then one cut by STOP
        bus_start();
        for (int i = 0; i < 4; i++) bus_bit(i[0], s);
        bus_start();
        send_byte({DEV, 1'b1}, a);
        check(a, "R2 START mid-byte restarts address", a, 1);
        recv_byte(v, 1'b0);
        check(v == mem[8'h07], "R2 read after restart", v, mem[8'h07]);
        bus_stop();
        bus_start();
        for (int i = 0; i < 3; i++) bus_bit(1'b0, s);
        bus_stop();
        check(sda_oe == 1'b0, "R2 idle after STOP mid-byte", sda_oe, 0);
        read_only("R2 read after aborted transfer");

        check(r11_bad == 0, "R11 no SDA change during SCL high", r11_bad, 0);
        check(wr_q.size() == 0, "R12 strobe queue drained", wr_q.size(), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule